// File: doc/BRIEF.md
# CEC Receive Bit-Timing Error Checker

This block follows the sampled CEC bus while a frame is being received and judges the waveform of every data bit against timing windows expressed in ticks of an external timebase (one tick is 0.05 ms). A data bit starts with a falling edge. Its rising edge must land near one of two nominal points: 12 ticks for a logic 1, or 30 ticks for a logic 0. The next falling edge must not come earlier than a minimum bit period. A rising edge outside both windows, or a rising edge that has not arrived when the later window closes, is a rise error. A falling edge that comes too soon is a short-period error.

On a short-period error the block always asks the line driver to hold the bus low as an error bit. On a rise error, two policy inputs decide the response. One asks for the error bit. The other asks the receiver to abandon the frame. The error-bit request stays high until 72 ticks (3.6 ms) have passed since the falling edge that opened the faulty bit. A separate receiver outside this block assembles the bytes and acts on the stop request.

Top module: `cec_rx_bit_checker`

## Requirements
- R1: When a falling edge follows the start of a bit by fewer than 41 ticks, with the rising edge already seen, `short_err_o` pulses high for one clock.
- R2: Every short-period error raises `err_drive_o` in the same cycle as the pulse, whatever the two policy inputs are.
- R3: A rising edge whose tick count since the bit's falling edge lies outside both [12-T, 12+T] and [30-T, 30+T] pulses `rise_err_o` at that edge.
- R4: When the line is still low once the count exceeds 30+T, `rise_err_o` pulses at that moment, before any rising edge. The rising edge that comes later raises no second pulse.
- R5: T is 4 ticks when `tol_ext_i` is 0 and 7 ticks when it is 1.
- R6: `stop_req_o` pulses together with a rise error only when `stop_on_rise_i` is 1. When `stop_on_rise_i` is 0 it never rises.
- R7: A rise error raises `err_drive_o` only when `gen_on_rise_i` is 1. The request stays high until 72 ticks have passed since the bit's opening falling edge, and bus activity during that time is ignored.
- R8: The line passes through a two-flop synchronizer before edge detection. All outputs are registered, are low after reset, and each error or stop pulse lasts exactly one clock.
- R9: While `rx_en_i` is 0 all outputs stay low and the checker returns to waiting for a bit start.
- R10: Bits whose rising edge lies inside a window and whose period is at least 41 ticks produce no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase strobe, one per 0.05 ms |
| rx_en_i | input | 1 | High while a frame is being received |
| line_i | input | 1 | Asynchronous CEC bus level |
| tol_ext_i | input | 1 | 0: standard tolerance, 1: extended tolerance |
| stop_on_rise_i | input | 1 | Policy: a rise error requests stopping reception |
| gen_on_rise_i | input | 1 | Policy: a rise error requests an error bit |
| rise_err_o | output | 1 | One-cycle rise-error pulse |
| short_err_o | output | 1 | One-cycle short-period pulse |
| err_drive_o | output | 1 | Request to hold the bus low as an error bit |
| stop_req_o | output | 1 | One-cycle request to abandon reception |

## Verification
The bench sends trains of well-formed 1 and 0 bits with rises spread across each window, which separates correct window decoding from false alarms. It also sends rises placed between the windows and just inside or outside the standard and extended edges, which show whether the tolerance select widens the right bounds. Bits that never rise in time, and bits cut short by an early fall, are sent under each policy combination. They tell the timeout path apart from the edge path, and the forced error bit apart from the policy-gated one. The same faulty patterns are repeated with reception disabled, and a behavioural per-clock model judges every output cycle, including the exact length of the error-bit request.

// File: rtl/cec_bt_pkg.sv
package cec_bt_pkg;

  typedef enum logic [2:0] {
    BT_IDLE,  // waiting for the falling edge that opens a bit
    BT_LOW,   // line low, waiting for the rising edge
    BT_LATE,  // rise already declared late, waiting for it quietly
    BT_HIGH,  // line high, waiting for the next falling edge
    BT_ERR    // error bit requested, bus ignored
  } bt_state_e;

  // true when count c lies within nom +/- tol (inclusive)
  function automatic logic in_window(int unsigned c, int unsigned nom, int unsigned tol);
    return (c + tol >= nom) && (c <= nom + tol);
  endfunction

endpackage

// File: rtl/cec_bt_sync.sv
module cec_bt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] stg;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b1;
        else     stg[i] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b1;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= stg[STAGES-1];
  end

  assign level_o = stg[STAGES-1];
  assign rise_o  = stg[STAGES-1] & ~prev_q;
  assign fall_o  = ~stg[STAGES-1] & prev_q;

endmodule

// File: rtl/cec_bt_timer.sv
module cec_bt_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                            cnt_o <= '0;
    else if (restart_i)                 cnt_o <= '0;
    else if (tick_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/cec_bt_fsm.sv
module cec_bt_fsm
  import cec_bt_pkg::*;
#(
  parameter int W          = 8,
  parameter int ONE_RISE   = 12,
  parameter int ZERO_RISE  = 30,
  parameter int TOL_STD    = 4,
  parameter int TOL_EXT    = 7,
  parameter int BIT_MIN    = 41,
  parameter int ERR_TICKS  = 72
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         tol_ext_i,
  input  logic         stop_pol_i,
  input  logic         gen_pol_i,
  output logic         restart_o,
  output logic         rise_err_o,
  output logic         short_err_o,
  output logic         drive_o,
  output logic         stop_o
);

  bt_state_e   st_q, st_d;
  int unsigned c, tol;
  logic        rerr, serr;

  assign c   = 32'(cnt_i);
  assign tol = tol_ext_i ? TOL_EXT : TOL_STD;

  always_comb begin
    st_d      = st_q;
    restart_o = 1'b0;
    rerr      = 1'b0;
    serr      = 1'b0;
    if (!en_i) begin
      st_d = BT_IDLE;
    end else begin
      case (st_q)
        BT_IDLE: if (fall_i) begin
          st_d      = BT_LOW;
          restart_o = 1'b1;
        end
        BT_LOW: begin
          if (rise_i) begin
            st_d = BT_HIGH;
            rerr = !(in_window(c, ONE_RISE, tol) || in_window(c, ZERO_RISE, tol));
          end else if (c > ZERO_RISE + tol) begin
            st_d = BT_LATE;
            rerr = 1'b1;
          end
          if (rerr) begin
            if (gen_pol_i)       st_d = BT_ERR;
            else if (stop_pol_i) st_d = BT_IDLE;
          end
        end
        BT_LATE: if (rise_i) st_d = BT_HIGH;
        BT_HIGH: if (fall_i) begin
          if (c < BIT_MIN) begin
            serr = 1'b1;
            st_d = BT_ERR;
          end else begin
            st_d      = BT_LOW;
            restart_o = 1'b1;
          end
        end
        BT_ERR: if (c >= ERR_TICKS) st_d = BT_IDLE;
        default: st_d = BT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= BT_IDLE;
      rise_err_o  <= 1'b0;
      short_err_o <= 1'b0;
      drive_o     <= 1'b0;
      stop_o      <= 1'b0;
    end else begin
      st_q        <= st_d;
      rise_err_o  <= rerr;
      short_err_o <= serr;
      drive_o     <= (st_d == BT_ERR);
      stop_o      <= rerr & stop_pol_i;
    end
  end

endmodule

// File: rtl/cec_rx_bit_checker.sv
module cec_rx_bit_checker #(
  parameter int SYNC_STAGES = 2,
  parameter int ONE_RISE    = 12,
  parameter int ZERO_RISE   = 30,
  parameter int TOL_STD     = 4,
  parameter int TOL_EXT     = 7,
  parameter int BIT_MIN     = 41,
  parameter int ERR_TICKS   = 72
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic rx_en_i,
  input  logic line_i,
  input  logic tol_ext_i,
  input  logic stop_on_rise_i,
  input  logic gen_on_rise_i,
  output logic rise_err_o,
  output logic short_err_o,
  output logic err_drive_o,
  output logic stop_req_o
);

  // one spare bit so the saturated value stays above every threshold
  localparam int CNT_W = $clog2(ERR_TICKS + 1) + 1;

  logic             lvl, rise, fall, restart;
  logic [CNT_W-1:0] cnt;

  cec_bt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_i),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  cec_bt_timer #(.W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .restart_i (restart),
    .cnt_o     (cnt)
  );

  cec_bt_fsm #(
    .W         (CNT_W),
    .ONE_RISE  (ONE_RISE),
    .ZERO_RISE (ZERO_RISE),
    .TOL_STD   (TOL_STD),
    .TOL_EXT   (TOL_EXT),
    .BIT_MIN   (BIT_MIN),
    .ERR_TICKS (ERR_TICKS)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en_i        (rx_en_i),
    .cnt_i       (cnt),
    .rise_i      (rise),
    .fall_i      (fall),
    .tol_ext_i   (tol_ext_i),
    .stop_pol_i  (stop_on_rise_i),
    .gen_pol_i   (gen_on_rise_i),
    .restart_o   (restart),
    .rise_err_o  (rise_err_o),
    .short_err_o (short_err_o),
    .drive_o     (err_drive_o),
    .stop_o      (stop_req_o)
  );

  logic unused_lvl;
  assign unused_lvl = lvl;

endmodule

// File: rtl/cec_bt_checker.sv
module cec_bt_checker (
  input logic clk,
  input logic rst,
  input logic rx_en_i,
  input logic stop_on_rise_i,
  input logic gen_on_rise_i,
  input logic rise_err_o,
  input logic short_err_o,
  input logic err_drive_o,
  input logic stop_req_o
);

  assert_short_forces_drive_R2: assert property (@(posedge clk) disable iff (rst)
    short_err_o |-> err_drive_o);

  assert_rise_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    rise_err_o |=> !rise_err_o);

  assert_short_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    short_err_o |=> !short_err_o);

  assert_stop_needs_policy_R6: assert property (@(posedge clk) disable iff (rst)
    stop_req_o |-> (rise_err_o && $past(stop_on_rise_i)));

  assert_gen_policy_drives_R7: assert property (@(posedge clk) disable iff (rst)
    (rise_err_o && $past(gen_on_rise_i)) |-> err_drive_o);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_en_i) |-> !(rise_err_o || short_err_o || err_drive_o || stop_req_o));

  assert_one_error_kind_R1: assert property (@(posedge clk) disable iff (rst)
    !(rise_err_o && short_err_o));

endmodule

bind cec_rx_bit_checker cec_bt_checker u_chk (.*);

// File: tb/tb_cec_rx_bit_checker.sv
module tb_cec_rx_bit_checker;

  localparam int TD = 3;  // clocks per tick

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, rx_en = 1'b1, line_lvl = 1'b1;
  logic tol_ext = 1'b0, stop_pol = 1'b0, gen_pol = 1'b0;
  logic rise_err, short_err, err_drive, stop_req;

  always #10 clk = ~clk;

  cec_rx_bit_checker dut (
    .clk(clk), .rst(rst), .tick_i(tick), .rx_en_i(rx_en), .line_i(line_lvl),
    .tol_ext_i(tol_ext), .stop_on_rise_i(stop_pol), .gen_on_rise_i(gen_pol),
    .rise_err_o(rise_err), .short_err_o(short_err),
    .err_drive_o(err_drive), .stop_req_o(stop_req)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick generator
  int tdiv = 0;
  always @(negedge clk) begin
    if (rst) begin tick <= 1'b0; tdiv <= 0; end
    else begin
      tick <= (tdiv == TD - 1);
      tdiv <= (tdiv == TD - 1) ? 0 : tdiv + 1;
    end
  end

  // behavioural reference: 0 idle, 1 low, 2 late, 3 high, 4 error bit
  int  h[4];
  int  ms, mc, nx, tl;
  bit  mfall, mrise, win, rst_cnt, re, se;
  bit  e_re, e_se, e_dr, e_st;

  always @(posedge clk) begin
    if (rst) begin
      h = '{1, 1, 1, 1}; ms = 0; mc = 0;
      e_re = 0; e_se = 0; e_dr = 0; e_st = 0;
    end else begin
      mfall = (h[2] == 1 && h[1] == 0);
      mrise = (h[2] == 0 && h[1] == 1);
      tl = tol_ext ? 7 : 4;
      win = (mc >= 12 - tl && mc <= 12 + tl) || (mc >= 30 - tl && mc <= 30 + tl);
      nx = ms; rst_cnt = 0; re = 0; se = 0;
      if (!rx_en) nx = 0;
      else if (ms == 0) begin
        if (mfall) begin nx = 1; rst_cnt = 1; end
      end else if (ms == 1) begin
        if (mrise) begin re = !win; nx = 3; end
        else if (mc > 30 + tl) begin re = 1; nx = 2; end
        if (re && gen_pol) nx = 4;
        else if (re && stop_pol) nx = 0;
      end else if (ms == 2) begin
        if (mrise) nx = 3;
      end else if (ms == 3) begin
        if (mfall) begin
          if (mc < 41) begin se = 1; nx = 4; end
          else begin nx = 1; rst_cnt = 1; end
        end
      end else begin
        if (mc >= 72) nx = 0;
      end
      e_re = re; e_se = se; e_st = re && stop_pol; e_dr = (nx == 4);
      ms = nx;
      if (rst_cnt) mc = 0;
      else if (tick && mc < 1000) mc++;
      h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = line_lvl;
    end
  end

  // per-clock comparison and pulse counters
  int c_rise = 0, c_short = 0, c_stop = 0, c_drv = 0, c_late = 0;
  bit p_rise = 0, p_short = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(rise_err == e_re,  "R3 rise_err vs model",  rise_err,  e_re);
      chk(short_err == e_se, "R1 short_err vs model", short_err, e_se);
      chk(err_drive == e_dr, "R7 err_drive vs model", err_drive, e_dr);
      chk(stop_req == e_st,  "R6 stop_req vs model",  stop_req,  e_st);
      if (rise_err) chk(!p_rise, "R8 rise pulse width", 2, 1);
      if (short_err) chk(!p_short, "R8 short pulse width", 2, 1);
      if (rise_err) c_rise++;
      if (rise_err && !line_lvl) c_late++;
      if (short_err) c_short++;
      if (stop_req) c_stop++;
      if (err_drive) c_drv++;
      p_rise = rise_err; p_short = short_err;
    end
  end

  task automatic wait_ticks(int n);
    repeat (n * TD) @(negedge clk);
  endtask

  task automatic send_bit(int r, int p);
    line_lvl = 1'b0;
    wait_ticks(r);
    line_lvl = 1'b1;
    wait_ticks(p - r);
  endtask

  int b_rise, b_short, b_stop, b_drv, b_late;
  task automatic mark(bit te, bit sp, bit gp, bit en);
    line_lvl = 1'b1;
    wait_ticks(90);
    tol_ext = te; stop_pol = sp; gen_pol = gp; rx_en = en;
    wait_ticks(2);
    b_rise = c_rise; b_short = c_short; b_stop = c_stop; b_drv = c_drv; b_late = c_late;
  endtask

  task automatic finish_scen();
    line_lvl = 1'b1;
    wait_ticks(90);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!(rise_err || short_err || err_drive || stop_req), "R8 reset outputs low",
        {rise_err, short_err, err_drive, stop_req}, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R10: well-formed bits, both policies on so any false alarm shows
    mark(0, 1, 1, 1);
    send_bit(12, 48); send_bit(30, 48); send_bit(14, 48); send_bit(28, 48); send_bit(10, 48);
    finish_scen();
    chk(c_rise - b_rise == 0 && c_short - b_short == 0, "R10 valid bits no errors",
        c_rise - b_rise + c_short - b_short, 0);
    chk(c_drv - b_drv == 0 && c_stop - b_stop == 0, "R10 valid bits no drive/stop",
        c_drv - b_drv + c_stop - b_stop, 0);

    // R3: rise between windows, no policy
    mark(0, 0, 0, 1);
    send_bit(20, 48);
    finish_scen();
    chk(c_rise - b_rise == 1, "R3 misplaced rise flagged", c_rise - b_rise, 1);
    chk(c_drv - b_drv == 0, "R7 no drive without gen policy", c_drv - b_drv, 0);
    chk(c_stop - b_stop == 0, "R6 no stop without stop policy", c_stop - b_stop, 0);

    // R5: tolerance select, standard rejects, extended accepts
    mark(0, 0, 0, 1);
    send_bit(18, 48); send_bit(24, 48);
    finish_scen();
    chk(c_rise - b_rise == 2, "R5 standard tolerance rejects 18 and 24", c_rise - b_rise, 2);
    mark(1, 0, 0, 1);
    send_bit(18, 48); send_bit(24, 48);
    finish_scen();
    chk(c_rise - b_rise == 0, "R5 extended tolerance accepts 18 and 24", c_rise - b_rise, 0);
    mark(1, 0, 0, 1);
    send_bit(21, 48);
    finish_scen();
    chk(c_rise - b_rise == 1, "R5 extended tolerance rejects 21", c_rise - b_rise, 1);

    // R4: rise never in time, flagged while line still low, once only
    mark(0, 0, 0, 1);
    send_bit(42, 48);
    finish_scen();
    chk(c_rise - b_rise == 1, "R4 late rise single pulse", c_rise - b_rise, 1);
    chk(c_late - b_late == 1, "R4 flagged before the rise", c_late - b_late, 1);
    mark(1, 0, 0, 1);
    send_bit(40, 48);
    finish_scen();
    chk(c_late - b_late == 1, "R4 extended timeout flagged", c_late - b_late, 1);

    // R6: stop policy only
    mark(0, 1, 0, 1);
    send_bit(20, 48); send_bit(12, 48);
    finish_scen();
    chk(c_stop - b_stop == 1, "R6 stop request on rise error", c_stop - b_stop, 1);
    chk(c_drv - b_drv == 0, "R6 stop policy alone no drive", c_drv - b_drv, 0);

    // R7: generate policy, error bit held to 72 ticks from bit start
    mark(0, 0, 1, 1);
    send_bit(20, 48);
    finish_scen();
    chk(c_drv - b_drv >= 150 && c_drv - b_drv <= 162, "R7 error bit length",
        c_drv - b_drv, 156);
    chk(c_stop - b_stop == 0, "R7 gen policy alone no stop", c_stop - b_stop, 0);

    // R1, R2: short bit period, policies off
    mark(0, 0, 0, 1);
    send_bit(12, 30); send_bit(12, 48);
    finish_scen();
    chk(c_short - b_short == 1, "R1 short period flagged", c_short - b_short, 1);
    chk(c_drv - b_drv > 100, "R2 short period forces drive", c_drv - b_drv, 126);
    chk(c_rise - b_rise == 0, "R1 no rise error on short bit", c_rise - b_rise, 0);

    // R9: faulty patterns with reception disabled
    mark(0, 1, 1, 0);
    send_bit(20, 48); send_bit(12, 30); send_bit(42, 48);
    finish_scen();
    chk(c_rise - b_rise + c_short - b_short + c_stop - b_stop + c_drv - b_drv == 0,
        "R9 disabled checker silent",
        c_rise - b_rise + c_short - b_short + c_stop - b_stop + c_drv - b_drv, 0);

    mark(0, 0, 0, 1);
    finish_scen();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule